// File: doc/BRIEF.md
# Rewindable Two-Clock FIFO

This block is a one-way first-in first-out buffer. A producer writes on one clock and a consumer reads on an unrelated clock. Besides ordinary streaming, the consumer can ask for a replay. The read position then walks back to the first word stored since reset, and everything kept from that point on can be read again, in its original order. Words written while the replay is being prepared, or after it, still come out afterwards, behind the older words.

Each port has an enable and an active-low select. The write side reports `wr_room`, which is high while a word can be accepted. The read side reports `rd_avail`, which is high while a word can be taken. While a replay is being prepared, `rd_avail` is held low, and reads are refused until it rises again. The two positions cross between the clock domains as Gray codes through two-flop synchronizers.

The replay sequencer in the read domain has three named states. `RS_IDLE` is normal streaming. A qualified request in `RS_IDLE` moves it to `RS_REWIND`. In `RS_REWIND` the read position steps back one word per read clock. When the position reaches the start (zero), the sequencer moves to `RS_SETTLE`. It waits there `SETTLE_CYC` read clocks and then returns to `RS_IDLE`, where `rd_avail` is computed again. Between a reset and a replay, the user writes no more than DEPTH-2 words.

Top module: `rtx_fifo`

## Requirements
- R1: After reset `rd_avail` is 0, `wr_room` is 1 and `rd_data` is all zeros.
- R2: A read is accepted on a `rd_clk` rising edge when `rd_en`=1, `rd_cs_n`=0 and `rd_avail`=1. The accepted word appears on `rd_data` after that edge. Words leave in the order they were written.
- R3: `wr_room` falls once DEPTH words are stored. A write while `wr_room`=0 is dropped. `wr_room` rises again once space is freed.
- R4: A read enable while `rd_avail`=0 has no effect. `rd_data` holds its value and no stored word is skipped.
- R5: With `wr_cs_n`=1 writes are ignored. With `rd_cs_n`=1 both reads and replay requests are ignored.
- R6: A replay starts on a `rd_clk` edge where `rt_req`=1, `rt_mode`=1 and `rd_cs_n`=0. With `rt_mode`=0 the request is ignored. If a read enable falls on the same edge, the replay wins and no word is read.
- R7: From the edge that starts a replay until setup ends, `rd_avail` stays 0 and read enables move neither `rd_data` nor the read position.
- R8: After a replay, the first word read is the first word written since reset. The rest follow in write order, including words written during or after the setup.
- R9: Setup rewinds the read position one word per read clock and then waits `SETTLE_CYC` read clocks. `rd_avail` returns to 1 within W+`SETTLE_CYC`+6 read clocks of the request, where W is the number of words written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write enable |
| wr_cs_n | input | 1 | Write port select, active low |
| wr_data | input | DW | Word to store |
| wr_room | output | 1 | High while a write can be accepted |
| rd_en | input | 1 | Read enable |
| rd_cs_n | input | 1 | Read port select, active low |
| rt_req | input | 1 | Replay request |
| rt_mode | input | 1 | Replay qualifier; must be high with `rt_req` |
| rd_data | output | DW | Registered output word |
| rd_avail | output | 1 | High while a read can be accepted |

## Verification
A replay request and a read enable can arrive on the same read clock edge. The bench provokes this after part of the stored data has been read, raising `rt_req`, `rt_mode` and `rd_en` in one cycle. It then checks that `rd_data` did not advance, that `rd_avail` fell, and that the next stream restarts from the first word written since reset. Words written during setup must also come out, at the end of the replayed stream, which shows that a write landing during setup is not lost.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_REWIND = 2'd1,
        RS_SETTLE = 2'd2
    } rt_state_e;
endpackage

// File: rtl/rtx_sync.sv
module rtx_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rtx_mem.sv
module rtx_mem #(
    parameter int DW = 36,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rtx_wr_ctrl.sv
module rtx_wr_ctrl #(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_cs_n,
    input  logic [AW:0]   rgray_s,
    output logic          wr_acc,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          wr_room
);
    logic [AW:0] wbin, wbin_nx, wgray_nx;
    logic        full_nx;

    always_comb begin
        wr_acc   = wr_en & ~wr_cs_n & wr_room;
        wbin_nx  = wbin + (AW+1)'(wr_acc);
        wgray_nx = wbin_nx ^ (wbin_nx >> 1);
        full_nx  = (wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            wr_room <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wgray_nx;
            wr_room <= ~full_nx;
        end
    end

    assign waddr = wbin[AW-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !wr_cs_n && !wr_room) |=> $stable(wbin)); // R3
    AST_WR_CS_BLOCK: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_cs_n |=> $stable(wbin)); // R5
endmodule

// File: rtl/rtx_rd_ctrl.sv
module rtx_rd_ctrl
    import rtx_pkg::*;
#(
    parameter int AW         = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_cs_n,
    input  logic          rt_req,
    input  logic          rt_mode,
    input  logic [AW:0]   wgray_s,
    output logic          rd_acc,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          rd_avail
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    rt_state_e   state, nstate;
    logic [AW:0] rbin, rbin_nx, rgray_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic        rt_go, avail_nx;

    assign rt_go = rt_req & rt_mode & ~rd_cs_n;

    // next-state decision
    always_comb begin
        nstate = state;
        unique case (state)
            RS_IDLE:   if (rt_go) nstate = RS_REWIND;
            RS_REWIND: if (rbin == '0) nstate = RS_SETTLE;
            RS_SETTLE: if (cnt == CW'(SETTLE_CYC - 1)) nstate = RS_IDLE;
            default:   nstate = RS_IDLE;
        endcase
    end

    // datapath and outputs per state
    always_comb begin
        rd_acc  = 1'b0;
        rbin_nx = rbin;
        cnt_nx  = cnt;
        unique case (state)
            RS_IDLE: begin
                if (!rt_go && rd_en && !rd_cs_n && rd_avail) begin
                    rd_acc  = 1'b1;
                    rbin_nx = rbin + (AW+1)'(1);
                end
            end
            RS_REWIND: begin
                if (rbin == '0) cnt_nx = '0;
                else            rbin_nx = rbin - (AW+1)'(1);
            end
            RS_SETTLE: cnt_nx = cnt + CW'(1);
            default: ;
        endcase
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
        avail_nx = (nstate == RS_IDLE) && (rgray_nx != wgray_s);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RS_IDLE;
            rbin     <= '0;
            rgray    <= '0;
            cnt      <= '0;
            rd_avail <= 1'b0;
        end else begin
            state    <= nstate;
            rbin     <= rbin_nx;
            rgray    <= rgray_nx;
            cnt      <= cnt_nx;
            rd_avail <= avail_nx;
        end
    end

    assign raddr = rbin[AW-1:0];

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (state == RS_IDLE && !rd_avail) |=> $stable(rbin)); // R4
    AST_RD_CS_BLOCK: assert property (@(posedge rclk) disable iff (!rst_n)
        (state == RS_IDLE && rd_cs_n) |=> ($stable(rbin) && state == RS_IDLE)); // R5
    AST_RT_START: assert property (@(posedge rclk) disable iff (!rst_n)
        (state == RS_IDLE && rt_req && rt_mode && !rd_cs_n) |=> (state == RS_REWIND)); // R6
    AST_SETUP_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        (state != RS_IDLE) |-> !rd_avail); // R7
    AST_REWIND_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
        (state == RS_REWIND && rbin != '0) |=> (rbin == $past(rbin) - (AW+1)'(1))); // R9
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
    parameter int DW         = 36,
    parameter int DEPTH      = 16,
    parameter int SETTLE_CYC = 2
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_cs_n,
    input  logic [DW-1:0] wr_data,
    output logic          wr_room,
    input  logic          rd_en,
    input  logic          rd_cs_n,
    input  logic          rt_req,
    input  logic          rt_mode,
    output logic [DW-1:0] rd_data,
    output logic          rd_avail
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_acc, rd_acc;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] mem_q;

    rtx_wr_ctrl #(.AW(AW)) u_wr (
        .wclk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs_n(wr_cs_n),
        .rgray_s(rgray_s), .wr_acc(wr_acc), .waddr(waddr),
        .wgray(wgray), .wr_room(wr_room)
    );

    rtx_rd_ctrl #(.AW(AW), .SETTLE_CYC(SETTLE_CYC)) u_rd (
        .rclk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_cs_n(rd_cs_n),
        .rt_req(rt_req), .rt_mode(rt_mode), .wgray_s(wgray_s),
        .rd_acc(rd_acc), .raddr(raddr), .rgray(rgray), .rd_avail(rd_avail)
    );

    rtx_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    rtx_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    rtx_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_acc) rd_data <= mem_q;
    end

    AST_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_avail |=> $stable(rd_data)); // R4
endmodule

// File: tb/sim_rtx_fifo.sv
module sim_rtx_fifo;
    localparam int DW = 36, DEPTH = 16, SETTLE = 2;

    logic wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic wr_en = 0, wr_cs_n = 1, rd_en = 0, rd_cs_n = 1, rt_req = 0, rt_mode = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_room, rd_avail;

    logic [DW-1:0] hist[$];
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] e, held;
    int checks = 0, errors = 0;
    string mon_tag = "R2";
    bit done = 0;

    always #10 rd_clk = ~rd_clk;   // 50 MHz
    always #17 wr_clk = ~wr_clk;

    rtx_fifo #(.DW(DW), .DEPTH(DEPTH), .SETTLE_CYC(SETTLE)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_cs_n(wr_cs_n), .wr_data(wr_data), .wr_room(wr_room),
        .rd_en(rd_en), .rd_cs_n(rd_cs_n), .rt_req(rt_req), .rt_mode(rt_mode),
        .rd_data(rd_data), .rd_avail(rd_avail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(posedge rd_clk) begin
        if (rst_n) begin
            if (rt_req && rt_mode && !rd_cs_n) begin
                exp_q = hist;
            end else if (rd_en && !rd_cs_n && rd_avail) begin
                #5;
                if (exp_q.size() == 0) chk(0, mon_tag, "unexpected word", rd_data, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e, mon_tag, "read word", rd_data, e);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge rd_clk);
        rst_n = 0; wr_en = 0; wr_cs_n = 1; rd_en = 0; rd_cs_n = 1; rt_req = 0; rt_mode = 0;
        hist.delete(); exp_q.delete();
        repeat (3) @(negedge rd_clk);
        rst_n = 1;
        repeat (3) @(negedge rd_clk);
        rd_cs_n = 0;
    endtask

    task automatic wr_burst(input int n, input logic [DW-1:0] base, input bit cs_n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1; wr_cs_n = cs_n; wr_data = base + DW'(i);
            if (!cs_n && wr_room) begin
                hist.push_back(wr_data);
                exp_q.push_back(wr_data);
            end
        end
        @(negedge wr_clk);
        wr_en = 0; wr_cs_n = 1;
    endtask

    task automatic rd_drain(input string tag);
        int lowrun = 0;
        mon_tag = tag;
        @(negedge rd_clk);
        rd_en = 1;
        for (int i = 0; i < 600 && lowrun < 10; i++) begin
            @(negedge rd_clk);
            if (rd_avail) lowrun = 0; else lowrun++;
        end
        rd_en = 0;
        chk(exp_q.size() == 0, tag, "words left unread", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge rd_clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cyc;
        do_reset();
        // R1 reset state
        chk(rd_avail == 0, "R1", "rd_avail after reset", rd_avail, 0);
        chk(wr_room == 1, "R1", "wr_room after reset", wr_room, 1);
        chk(rd_data == 0, "R1", "rd_data after reset", rd_data, 0);

        // R2 streaming order
        wr_burst(5, 36'h100, 0);
        repeat (10) @(negedge rd_clk);
        rd_drain("R2");

        // R4 read while empty
        held = rd_data;
        rd_en = 1;
        repeat (5) @(negedge rd_clk);
        rd_en = 0;
        chk(rd_data == held, "R4", "rd_data moved while empty", rd_data, held);
        chk(rd_avail == 0, "R4", "rd_avail while empty", rd_avail, 0);
        wr_burst(2, 36'h200, 0);
        repeat (10) @(negedge rd_clk);
        rd_drain("R4");

        // R5 selects
        wr_burst(3, 36'h300, 1);
        repeat (12) @(negedge rd_clk);
        chk(rd_avail == 0, "R5", "write with wr_cs_n high stored", rd_avail, 0);
        wr_burst(2, 36'h400, 0);
        repeat (12) @(negedge rd_clk);
        chk(rd_avail == 1, "R5", "data ready", rd_avail, 1);
        held = rd_data;
        rd_cs_n = 1; rd_en = 1;
        repeat (4) @(negedge rd_clk);
        chk(rd_data == held, "R5", "read with rd_cs_n high", rd_data, held);
        rd_en = 0; rt_req = 1; rt_mode = 1;
        @(negedge rd_clk);
        rt_req = 0; rt_mode = 0;
        @(negedge rd_clk);
        chk(rd_avail == 1, "R5", "replay with rd_cs_n high", rd_avail, 1);
        rd_cs_n = 0;
        rd_drain("R5");

        // R6 request without qualifier
        wr_burst(2, 36'h500, 0);
        repeat (12) @(negedge rd_clk);
        rt_req = 1; rt_mode = 0;
        @(negedge rd_clk);
        rt_req = 0;
        @(negedge rd_clk);
        chk(rd_avail == 1, "R6", "replay without rt_mode", rd_avail, 1);
        rd_drain("R6");

        // R7 R8 R9 replay with reads held and writes during setup
        mon_tag = "R8";
        @(negedge rd_clk);
        rt_req = 1; rt_mode = 1; rd_en = 1;
        @(negedge rd_clk);
        rt_req = 0; rt_mode = 0;
        chk(rd_avail == 0, "R7", "rd_avail after replay request", rd_avail, 0);
        held = rd_data;
        fork
            wr_burst(2, 36'h600, 0);
        join_none
        cyc = 1;
        while (!rd_avail && cyc < 60) begin
            @(negedge rd_clk);
            cyc++;
            chk(rd_avail || rd_data == held, "R7", "rd_data moved during setup", rd_data, held);
        end
        chk(cyc <= 11 + SETTLE + 6, "R9", "setup length", cyc, 11 + SETTLE + 6);
        wait fork;
        repeat (12) @(negedge rd_clk);
        rd_drain("R8");

        // R6 replay and read on the same edge
        @(negedge rd_clk);
        rt_req = 1; rt_mode = 1;
        @(negedge rd_clk);
        rt_req = 0; rt_mode = 0;
        repeat (30) @(negedge rd_clk);
        chk(rd_avail == 1, "R9", "rd_avail back after setup", rd_avail, 1);
        rd_en = 1;
        repeat (3) @(negedge rd_clk);
        held = rd_data;
        rt_req = 1; rt_mode = 1;
        @(negedge rd_clk);
        rt_req = 0; rt_mode = 0; rd_en = 0;
        chk(rd_data == held, "R6", "read accepted with replay", rd_data, held);
        chk(rd_avail == 0, "R6", "replay not started", rd_avail, 0);
        repeat (30) @(negedge rd_clk);
        rd_drain("R8");

        // R3 full
        do_reset();
        mon_tag = "R3";
        wr_burst(DEPTH + 3, 36'h700, 0);
        chk(hist.size() == DEPTH, "R3", "words accepted", hist.size(), DEPTH);
        chk(wr_room == 0, "R3", "wr_room when full", wr_room, 0);
        repeat (10) @(negedge rd_clk);
        rd_drain("R3");
        repeat (6) @(negedge wr_clk);
        chk(wr_room == 1, "R3", "wr_room after drain", wr_room, 1);

        finish_run();
    end
endmodule